// File: doc/BRIEF.md
# Fixed Off-Time H-Bridge Chopper Controller

This block is the digital control core for a single motor winding driven by a full H-bridge. It produces four gate-enable outputs, a high-side (source) and a low-side (sink) switch on each of the two bridge legs. It regulates the winding current by chopping with a fixed off-time. During the on-period a diagonal pair conducts. A registered comparator trip ends the on-period. A programmable off-time then runs, and the pair is re-enabled when it expires.

The direction bit chooses which diagonal pair conducts. A 3-bit level code is passed straight through to an external reference DAC, which sets the trip threshold. A level code of zero turns the whole bridge off. A 2-bit decay select chooses which switches stay on during the off-time:

- Slow decay keeps the active sink on, so current recirculates through the low side.
- Fast decay turns everything off.
- Mixed decay runs fast for a parameterised number of cycles, then slow.

Any change of direction forces an all-off dead interval before the new pair is enabled. A synchronous reset applies the same dead interval.

Top module: `hbridge_chopper`

## Requirements
- R1: While `rst` is high all four gate outputs are low. After the last reset edge, all outputs stay low for exactly DEAD_CYC cycles before the first on-period begins.
- R2: In the on-period, `dir_i`=0 enables `src_a_o` and `snk_b_o`, and `dir_i`=1 enables `src_b_o` and `snk_a_o`. The source and sink of the same leg are never on together.
- R3: `trip_i` is registered. A trip sampled high at a clock edge during the on-period ends the on-period at the following edge. The off-time then lasts `off_cycles_i` cycles (a value of 0 acts as 1), after which the same pair is re-enabled.
- R4: Slow decay (`decay_i`=2'b00): during the off-time only the sink of the active pair stays on (`snk_b_o` for dir 0, `snk_a_o` for dir 1).
- R5: Fast decay (`decay_i`=2'b01): all four outputs are low for the whole off-time.
- R6: Mixed decay (`decay_i`=2'b10 or 2'b11): all outputs are low for the first MIX_FAST_CYC cycles of the off-time, then slow-decay gating applies for the rest.
- R7: A change of `dir_i` sampled at a clock edge turns all outputs off from that edge for DEAD_CYC cycles. The pair for the new direction is then enabled.
- R8: When `level_i` is 3'b000, all four outputs are low in the same cycle, whatever the other inputs are. Timing continues underneath.
- R9: `dac_code_o` always equals `level_i`.
- R10: Trips sampled during the off-time or the dead time are ignored. They neither extend the off-time nor start a new one.
- R11: A direction change during an off-time cancels the off-time and starts a dead interval. The next on-period follows directly after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_i | input | 1 | Current direction select |
| level_i | input | 3 | Current level code; 0 turns the bridge off |
| decay_i | input | 2 | Decay select: 00 slow, 01 fast, 1x mixed |
| trip_i | input | 1 | Synchronous current-comparator trip |
| off_cycles_i | input | OFF_W | Off-time length in clock cycles |
| src_a_o | output | 1 | Leg A high-side enable |
| snk_a_o | output | 1 | Leg A low-side enable |
| src_b_o | output | 1 | Leg B high-side enable |
| snk_b_o | output | 1 | Leg B low-side enable |
| dac_code_o | output | 3 | Level index for the reference DAC |

## Verification
The main collision is a comparator trip and a direction change landing in the same cycle, or a direction flip in the middle of an off-time. In either case the dead interval must win, and the stale trip must not start an off-time after the dead interval. The random stimulus pulses `trip_i` often and flips `dir_i` rarely, so both collisions recur many times per run. A second collision is a trip arriving in the very cycle an off-time expires. The bench judges every cycle against a cycle model built from the requirements, which tracks phase, countdown and mixed-decay elapsed time.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;
   typedef enum logic [1:0] {
      PH_DEAD = 2'd0,
      PH_ON   = 2'd1,
      PH_OFF  = 2'd2
   } phase_t;

   localparam logic [1:0] DK_SLOW = 2'b00;
   localparam logic [1:0] DK_FAST = 2'b01;
endpackage

// File: rtl/chop_trip_sync.sv
`timescale 1ns/1ps
module chop_trip_sync (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   input  logic trip_i,
   output logic trip_q
);
   // capture only while the bridge is conducting
   always_ff @(posedge clk) begin
      if (rst) trip_q <= 1'b0;
      else     trip_q <= trip_i & arm;
   end
endmodule

// File: rtl/chop_timer.sv
`timescale 1ns/1ps
module chop_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (ld)                        cnt_q <= ld_val;
      else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/chop_gate_map.sv
`timescale 1ns/1ps
module chop_gate_map #(
   parameter int MIX_FAST_CYC = 4
) (
   input  chop_pkg::phase_t phase,
   input  logic             dir,
   input  logic [1:0]       decay,
   input  logic             early,
   input  logic             level_nz,
   output logic [3:0]       gates   // {src_a, snk_a, src_b, snk_b}
);
   import chop_pkg::*;

   logic hold_sink;

   generate
      if (MIX_FAST_CYC == 0) begin : g_mix_slow
         // no fast window: mixed behaves as slow
         assign hold_sink = (decay != DK_FAST) | (early & 1'b0);
      end else begin : g_mix_split
         assign hold_sink = (decay == DK_SLOW) | (decay[1] & ~early);
      end
   endgenerate

   always_comb begin
      gates = 4'b0000;
      if (level_nz) begin
         unique case (phase)
            PH_ON:   gates = dir ? 4'b0110 : 4'b1001;
            PH_OFF:  if (hold_sink) gates = dir ? 4'b0100 : 4'b0001;
            default: gates = 4'b0000;
         endcase
      end
   end
endmodule

// File: rtl/hbridge_chopper.sv
`timescale 1ns/1ps
module hbridge_chopper #(
   parameter int DEAD_CYC     = 50,
   parameter int OFF_W        = 8,
   parameter int MIX_FAST_CYC = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dir_i,
   input  logic [2:0]       level_i,
   input  logic [1:0]       decay_i,
   input  logic             trip_i,
   input  logic [OFF_W-1:0] off_cycles_i,
   output logic             src_a_o,
   output logic             snk_a_o,
   output logic             src_b_o,
   output logic             snk_b_o,
   output logic [2:0]       dac_code_o
);
   import chop_pkg::*;

   localparam int DW    = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
   localparam int CNT_W = (DW > OFF_W) ? DW : OFF_W;
   localparam int EL_W  = (MIX_FAST_CYC > 0) ? $clog2(MIX_FAST_CYC + 1) : 1;
   localparam logic [CNT_W-1:0] DEAD_LD = CNT_W'(DEAD_CYC - 1);

   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("DEAD_CYC must be at least 1");
      end
      if (OFF_W < 1) begin : g_bad_off
         $error("OFF_W must be at least 1");
      end
      if (MIX_FAST_CYC < 0) begin : g_bad_mix
         $error("MIX_FAST_CYC must not be negative");
      end
   endgenerate

   phase_t           phase_q;
   logic             dir_q;
   logic             trip_q;
   logic             tmr_zero;
   logic             tmr_ld;
   logic [CNT_W-1:0] tmr_val;
   logic [CNT_W-1:0] off_ld;
   logic [EL_W-1:0]  el_q;
   logic             early;
   logic             dir_chg;
   logic             trip_hit;
   logic [3:0]       gates;

   assign dir_chg  = (dir_i != dir_q);
   assign trip_hit = (phase_q == PH_ON) & trip_q & ~dir_chg;
   assign off_ld   = (off_cycles_i == '0) ? '0 : CNT_W'(off_cycles_i - 1'b1);
   assign tmr_ld   = rst | dir_chg | trip_hit;
   assign tmr_val  = (rst | dir_chg) ? DEAD_LD : off_ld;

   chop_trip_sync u_trip (
      .clk    (clk),
      .rst    (rst),
      .arm    (phase_q == PH_ON),
      .trip_i (trip_i),
      .trip_q (trip_q)
   );

   chop_timer #(.W(CNT_W)) u_tmr (
      .clk    (clk),
      .ld     (tmr_ld),
      .ld_val (tmr_val),
      .dec    (phase_q != PH_ON),
      .zero   (tmr_zero)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_DEAD;
         dir_q   <= 1'b0;
      end else if (dir_chg) begin
         phase_q <= PH_DEAD;
         dir_q   <= dir_i;
      end else begin
         unique case (phase_q)
            PH_DEAD: if (tmr_zero) phase_q <= PH_ON;
            PH_ON:   if (trip_q)   phase_q <= PH_OFF;
            PH_OFF:  if (tmr_zero) phase_q <= PH_ON;
            default: phase_q <= PH_DEAD;
         endcase
      end
   end

   // elapsed off-time, saturating at the fast-decay window
   always_ff @(posedge clk) begin
      if (rst || trip_hit)                                    el_q <= '0;
      else if (phase_q == PH_OFF && el_q < EL_W'(MIX_FAST_CYC)) el_q <= el_q + 1'b1;
   end

   assign early = (el_q < EL_W'(MIX_FAST_CYC));

   chop_gate_map #(.MIX_FAST_CYC(MIX_FAST_CYC)) u_map (
      .phase    (phase_q),
      .dir      (dir_q),
      .decay    (decay_i),
      .early    (early),
      .level_nz (level_i != 3'b000),
      .gates    (gates)
   );

   assign {src_a_o, snk_a_o, src_b_o, snk_b_o} = gates;
   assign dac_code_o = level_i;
endmodule

// File: rtl/chop_chk.sv
`timescale 1ns/1ps
module chop_chk (
   input logic       clk,
   input logic       rst,
   input logic       dir_i,
   input logic [2:0] level_i,
   input logic       src_a_o,
   input logic       snk_a_o,
   input logic       src_b_o,
   input logic       snk_b_o,
   input logic [1:0] phase,
   input logic       trip_q
);
   import chop_pkg::*;

   // R2
   leg_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !(src_a_o && snk_a_o) && !(src_b_o && snk_b_o));

   // R8
   zero_level_off_chk: assert property (@(posedge clk) disable iff (rst)
      (level_i == 3'b000) |-> !(src_a_o || snk_a_o || src_b_o || snk_b_o));

   // R7
   dir_dead_chk: assert property (@(posedge clk) disable iff (rst)
      (dir_i != $past(dir_i)) |=> !(src_a_o || snk_a_o || src_b_o || snk_b_o));

   // R3
   trip_ends_on_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_ON && trip_q) |=> (phase != PH_ON));

   // R4
   off_no_source_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_OFF) |-> !(src_a_o || src_b_o));
endmodule

bind hbridge_chopper chop_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .dir_i   (dir_i),
   .level_i (level_i),
   .src_a_o (src_a_o),
   .snk_a_o (snk_a_o),
   .src_b_o (src_b_o),
   .snk_b_o (snk_b_o),
   .phase   (phase_q),
   .trip_q  (trip_q)
);

// File: tb/sim_hbridge_chopper.sv
`timescale 1ns/1ps
module sim_hbridge_chopper;
   localparam int DEAD = 50;
   localparam int OW   = 8;
   localparam int MIX  = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          dir_i = 1'b0;
   logic [2:0]    level_i = 3'd5;
   logic [1:0]    decay_i = 2'b00;
   logic          trip_i = 1'b0;
   logic [OW-1:0] off_cycles_i = 8'd6;
   logic          src_a_o, snk_a_o, src_b_o, snk_b_o;
   logic [2:0]    dac_code_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   hbridge_chopper #(.DEAD_CYC(DEAD), .OFF_W(OW), .MIX_FAST_CYC(MIX)) u0 (
      .clk(clk), .rst(rst), .dir_i(dir_i), .level_i(level_i), .decay_i(decay_i),
      .trip_i(trip_i), .off_cycles_i(off_cycles_i),
      .src_a_o(src_a_o), .snk_a_o(snk_a_o), .src_b_o(src_b_o), .snk_b_o(snk_b_o),
      .dac_code_o(dac_code_o)
   );

   // cycle model built from the requirements: 0 dead, 1 on, 2 off
   int m_ph  = 0;
   int m_cnt = DEAD - 1;
   int m_el  = 0;
   bit m_dir = 0;
   bit m_trq = 0;
   bit m_rstdead = 1;

   always @(posedge clk) begin
      bit ntrq;
      if (rst) begin
         m_ph = 0; m_cnt = DEAD - 1; m_dir = 0; m_trq = 0; m_el = 0; m_rstdead = 1;
      end else begin
         ntrq = trip_i && (m_ph == 1);
         if (dir_i != m_dir) begin
            m_ph = 0; m_cnt = DEAD - 1; m_dir = dir_i; m_rstdead = 0;
         end else begin
            case (m_ph)
               0: if (m_cnt == 0) m_ph = 1; else m_cnt--;
               1: if (m_trq) begin
                     m_ph = 2; m_el = 0;
                     m_cnt = (off_cycles_i == 0) ? 0 : int'(off_cycles_i) - 1;
                  end
               default: begin
                  if (m_cnt == 0) m_ph = 1; else m_cnt--;
                  m_el++;
               end
            endcase
         end
         m_trq = ntrq;
      end
   end

   function automatic logic [3:0] exp_gates(int ph, bit d, logic [2:0] lv,
                                             logic [1:0] dk, int el);
      logic [3:0] sink;
      sink = d ? 4'b0100 : 4'b0001;
      if (lv == 3'b000) return 4'b0000;
      if (ph == 1) return d ? 4'b0110 : 4'b1001;
      if (ph == 2) begin
         if (dk == 2'b00) return sink;
         if (dk == 2'b01) return 4'b0000;
         return (el < MIX) ? 4'b0000 : sink;
      end
      return 4'b0000;
   endfunction

   function automatic string req_of(int ph, logic [2:0] lv, logic [1:0] dk, bit rd);
      if (lv == 3'b000) return "R8";
      if (ph == 0) return rd ? "R1" : "R7/R11";
      if (ph == 1) return "R2/R3";
      if (dk == 2'b00) return "R4/R10";
      if (dk == 2'b01) return "R5/R10";
      return "R6/R10";
   endfunction

   task automatic check_now();
      logic [3:0] got, exp;
      got = {src_a_o, snk_a_o, src_b_o, snk_b_o};
      exp = rst ? 4'b0000 : exp_gates(m_ph, m_dir, level_i, decay_i, m_el);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s gates actual=%b expected=%b", rst ? "R1" : req_of(m_ph, level_i, decay_i, m_rstdead), got, exp);
      end
      n_run++;
      if (dac_code_o !== level_i) begin
         n_fail++;
         $display("FAIL R9 dac actual=%0d expected=%0d", dac_code_o, level_i);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      int n;
      void'($urandom(32'd1234));
      // R1: reset holds everything off
      repeat (4) begin @(negedge clk); check_now(); end
      rst = 1'b0;
      n = 0;
      do begin
         @(negedge clk); n++; check_now();
      end while (!src_a_o && n < 200);
      n_run++;
      if (n != DEAD) begin
         n_fail++;
         $display("FAIL R1 first on after reset actual=%0d expected=%0d", n, DEAD);
      end
      // R3: directed trip with off_cycles 0 treated as one cycle
      off_cycles_i = 8'd0; decay_i = 2'b01;
      trip_i = 1'b1; @(negedge clk); check_now(); trip_i = 1'b0;
      repeat (4) begin @(negedge clk); check_now(); end
      // R11: direction flip during an off-time, trip in the same cycle
      off_cycles_i = 8'd30; decay_i = 2'b00;
      trip_i = 1'b1; @(negedge clk); check_now(); trip_i = 1'b0;
      @(negedge clk); check_now();
      @(negedge clk); check_now();
      dir_i = 1'b1; trip_i = 1'b1;
      @(negedge clk); check_now(); trip_i = 1'b0;
      repeat (DEAD + 5) begin @(negedge clk); check_now(); end
      // R8: zero level while on
      level_i = 3'd0;
      repeat (3) begin @(negedge clk); check_now(); end
      level_i = 3'd7;
      // random phase across all decay modes
      for (int i = 0; i < 30000; i++) begin
         @(negedge clk);
         check_now();
         trip_i = ($urandom_range(0, 5) == 0);
         if ($urandom_range(0, 299) == 0) dir_i = ~dir_i;
         if ($urandom_range(0, 149) == 0) decay_i = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 99) == 0)  off_cycles_i = 8'($urandom_range(0, 20));
         if ($urandom_range(0, 199) == 0) level_i = 3'($urandom_range(0, 7));
      end
      done = 1;
      finish_run();
   end
endmodule